// File: doc/BRIEF.md
# Remapping SRAM Chip-Select Decoder

This block sits between an 8-bit processor bus (12-bit address, active-low read and write strobes) and a single 2K x 8 static RAM. It turns the bus address and strobes into the RAM's active-low chip enable, output enable and write enable, and drives the RAM's 11 address lines. Everything is combinational, so the RAM sees the decode in the same bus cycle.

A static two-bit mode input picks the memory layout. The flat layout opens a 1.5K window directly above the monitor ROM. The folded layout keeps that window and also folds the two high 256-byte pages 0xBxx and 0xFxx onto the bottom 512 bytes of the RAM, which the ROM would otherwise hide. A third layout treats the socket as holding a read-only part across the low 2K. A fourth layout turns the RAM off.

Top module: `sram_remap_decoder`

## Requirements
- R1: `ram_oe_n` equals `bus_rd_n` in every mode.
- R2: `ram_we_n` equals `bus_wr_n` in modes 0, 1 and 3. In mode 2 it is held high.
- R3: In every mode, `ram_ce_n` is high whenever `bus_rd_n` and `bus_wr_n` are both high.
- R4: Mode 0 (flat): with a strobe active, `ram_ce_n` is low exactly for bus addresses 0x200 to 0x7FF. `ram_addr` equals `bus_addr[10:0]`.
- R5: Mode 1 (folded): with a strobe active, `ram_ce_n` is low exactly for 0x200–0x7FF, 0xB00–0xBFF and 0xF00–0xFFF.
- R6: Mode 1 address mapping, defined only while `ram_ce_n` is low:
  - page 0xBxx goes to RAM 0x000 plus the low byte;
  - page 0xFxx goes to RAM 0x100 plus the low byte;
  - 0x200–0x7FF maps one-to-one.
- R7: In mode 1, no two enabled bus addresses produce the same RAM address.
- R8: Mode 2 (read-only socket): `ram_ce_n` is low exactly for addresses 0x000–0x7FF while `bus_rd_n` is low. A write alone never enables the part. `ram_addr` equals `bus_addr[10:0]`.
- R9: Mode 3 (off): `ram_ce_n` is never low. `ram_addr` equals `bus_addr[10:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 12 | Processor bus address |
| bus_rd_n | input | 1 | Active-low bus read strobe |
| bus_wr_n | input | 1 | Active-low bus write strobe |
| map_mode | input | 2 | Layout select: 0 flat, 1 folded, 2 read-only socket, 3 off |
| ram_ce_n | output | 1 | Active-low RAM chip enable |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| ram_we_n | output | 1 | Active-low RAM write enable |
| ram_addr | output | 11 | RAM address lines |

## Verification
The hardest condition to reach is an aliasing collision in folded mode. Two distinct enabled bus addresses landing on one RAM byte only shows up when the whole enabled space is compared against itself, not when single vectors are checked. The bench therefore sweeps all 4096 addresses under every strobe combination in every mode, and keeps an occupancy map of RAM locations hit by enabled folded-mode reads. Randomly drawn vectors and directed page-edge addresses (0x1FF/0x200, 0x7FF/0x800, 0xAFF/0xB00, 0xBFF/0xC00, 0xEFF/0xF00, 0xFFF) come first.

// File: rtl/sram_remap_pkg.sv
package sram_remap_pkg;
  localparam int BUS_AW   = 12;
  localparam int RAM_AW   = 11;
  localparam int PAGE_LSB = 8;

  typedef logic [BUS_AW-1:0] bus_addr_t;
  typedef logic [RAM_AW-1:0] ram_addr_t;

  typedef enum logic [1:0] {
    MAP_FLAT = 2'd0,
    MAP_FOLD = 2'd1,
    MAP_ROM  = 2'd2,
    MAP_OFF  = 2'd3
  } map_mode_e;

  // Window above the monitor ROM: top bit clear and not the lowest 512 bytes.
  function automatic logic flat_hit(input bus_addr_t a);
    return ~a[BUS_AW-1] & (a[BUS_AW-2] | a[BUS_AW-3]);
  endfunction

  // High pages whose two page-select bits just above the byte index are set.
  function automatic logic high_page_hit(input bus_addr_t a);
    return a[BUS_AW-1] & a[PAGE_LSB+1] & a[PAGE_LSB];
  endfunction

  function automatic logic fold_hit(input bus_addr_t a);
    return flat_hit(a) | high_page_hit(a);
  endfunction

  function automatic logic rom_hit(input bus_addr_t a);
    return ~a[BUS_AW-1];
  endfunction

  // Upper three RAM address bits in folded layout.
  function automatic logic [2:0] fold_top(input bus_addr_t a);
    logic [2:0] t;
    t[2] = ~a[BUS_AW-1] & a[BUS_AW-2];
    t[1] = ~a[BUS_AW-1] & a[PAGE_LSB+1];
    t[0] = (~a[BUS_AW-1] & a[PAGE_LSB]) | (a[BUS_AW-2] & a[PAGE_LSB]);
    return t;
  endfunction
endpackage

// File: rtl/sram_window_dec.sv
module sram_window_dec
  import sram_remap_pkg::*;
#(
  parameter int AW = BUS_AW
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  output logic          hit
);
  localparam int TOP = AW - 1;

  logic flat_w, fold_w, rom_w;

  always_comb begin
    flat_w = flat_hit(addr);
    fold_w = fold_hit(addr);
    rom_w  = rom_hit(addr);
  end

  always_comb begin
    unique case (map_mode_e'(mode))
      MAP_FLAT: hit = flat_w;
      MAP_FOLD: hit = fold_w;
      MAP_ROM:  hit = rom_w;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    // R5
    fold_hi_page_chk: assert (!(mode == MAP_FOLD && hit && addr[TOP]) ||
                              (addr[PAGE_LSB+1:PAGE_LSB] == 2'b11))
      else $error("folded high hit outside 0xB/0xF pages");
    // R4
    flat_window_chk: assert (!(mode == MAP_FLAT && hit) ||
                             (!addr[TOP] && addr[TOP-1:TOP-2] != 2'b00))
      else $error("flat hit outside window");
  end
endmodule

// File: rtl/sram_addr_fold.sv
module sram_addr_fold
  import sram_remap_pkg::*;
#(
  parameter int AW  = BUS_AW,
  parameter int RAW = RAM_AW
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     mode,
  output logic [RAW-1:0] ram_addr
);
  localparam int UPPER = RAW - PAGE_LSB;

  logic [2:0] top_fold;
  logic       fold_sel;

  always_comb begin
    top_fold = fold_top(addr);
    fold_sel = (mode == MAP_FOLD);
  end

  genvar i;
  generate
    for (i = 0; i < PAGE_LSB; i++) begin : g_low
      assign ram_addr[i] = addr[i];
    end
    for (i = 0; i < UPPER; i++) begin : g_up
      assign ram_addr[PAGE_LSB+i] = fold_sel ? top_fold[i] : addr[PAGE_LSB+i];
    end
  endgenerate

  always_comb begin
    // R6
    fold_low_chk: assert (!(fold_sel && addr[AW-1] && addr[PAGE_LSB+1:PAGE_LSB] == 2'b11) ||
                          (ram_addr[RAW-1:PAGE_LSB+1] == '0 && ram_addr[PAGE_LSB] == addr[AW-2]))
      else $error("high page not folded into low 512 bytes");
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_remap_pkg::*;
(
  input  logic       hit,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] mode,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n
);
  logic rom_sel, access;

  always_comb begin
    rom_sel = (mode == MAP_ROM);
    access  = rom_sel ? ~rd_n : ~(rd_n & wr_n);
    ce_n    = ~(hit & access);
    oe_n    = rd_n;
    we_n    = rom_sel | wr_n;
  end

  always_comb begin
    // R3
    idle_ce_chk: assert (!(rd_n && wr_n) || ce_n)
      else $error("chip enabled with no strobe");
  end
endmodule

// File: rtl/sram_remap_decoder.sv
module sram_remap_decoder
  import sram_remap_pkg::*;
#(
  parameter int AW  = BUS_AW,
  parameter int RAW = RAM_AW
) (
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd_n,
  input  logic           bus_wr_n,
  input  logic [1:0]     map_mode,
  output logic           ram_ce_n,
  output logic           ram_oe_n,
  output logic           ram_we_n,
  output logic [RAW-1:0] ram_addr
);
  logic win_hit;

  sram_window_dec #(.AW(AW)) u_win (
    .addr(bus_addr), .mode(map_mode), .hit(win_hit)
  );

  sram_addr_fold #(.AW(AW), .RAW(RAW)) u_fold (
    .addr(bus_addr), .mode(map_mode), .ram_addr(ram_addr)
  );

  sram_strobe_gen u_stb (
    .hit(win_hit), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .mode(map_mode),
    .ce_n(ram_ce_n), .oe_n(ram_oe_n), .we_n(ram_we_n)
  );

  always_comb begin
    // R9
    off_ce_chk: assert (map_mode != MAP_OFF || ram_ce_n)
      else $error("chip enabled in off mode");
    // R2
    rom_we_chk: assert (map_mode != MAP_ROM || ram_we_n)
      else $error("write enable in read-only mode");
    // R8
    rom_read_chk: assert (!(map_mode == MAP_ROM && !ram_ce_n) ||
                          (!bus_rd_n && !bus_addr[AW-1]))
      else $error("read-only socket enabled without read");
    // R4
    flat_addr_chk: assert (map_mode != MAP_FLAT || ram_addr == bus_addr[RAW-1:0])
      else $error("flat address not passed through");
  end
endmodule

// File: tb/sram_remap_decoder_test.sv
module sram_remap_decoder_test;
  logic        clk = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [1:0]  map_mode = 2'd0;
  logic        ram_ce_n, ram_oe_n, ram_we_n;
  logic [10:0] ram_addr;
  int errors = 0, checks = 0;
  logic occ [0:2047];

  always #10 clk = ~clk;

  sram_remap_decoder uut (
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .map_mode(map_mode), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_addr(ram_addr)
  );

  function automatic logic exp_ce_n(input logic [1:0] m, input logic [11:0] a,
                                    input logic rd, input logic wr);
    logic en;
    if (rd && wr) return 1'b1;
    case (m)
      2'd0: en = (a >= 12'h200 && a <= 12'h7FF);
      2'd1: en = (a >= 12'h200 && a <= 12'h7FF) || (a >= 12'hB00 && a <= 12'hBFF) ||
                 (a >= 12'hF00);
      2'd2: en = (a <= 12'h7FF) && !rd;
      default: en = 1'b0;
    endcase
    return ~en;
  endfunction

  function automatic logic [10:0] exp_addr(input logic [1:0] m, input logic [11:0] a);
    if (m == 2'd1 && a >= 12'hB00 && a <= 12'hBFF) return 11'h000 + 11'(a - 12'hB00);
    if (m == 2'd1 && a >= 12'hF00) return 11'h100 + 11'(a - 12'hF00);
    return a[10:0];
  endfunction

  task automatic apply(input logic [1:0] m, input logic [11:0] a, input logic rd,
                       input logic wr);
    logic ece, ewe;
    @(negedge clk);
    map_mode = m; bus_addr = a; bus_rd_n = rd; bus_wr_n = wr;
    #5;
    ece = exp_ce_n(m, a, rd, wr);
    ewe = (m == 2'd2) ? 1'b1 : wr;
    checks++;
    if (ram_ce_n !== ece) begin
      errors++;
      $display("FAIL %s ce mode=%0d addr=%h rd=%b wr=%b: got %b exp %b",
               (rd && wr) ? "R3" : (m == 0 ? "R4" : m == 1 ? "R5" : m == 2 ? "R8" : "R9"),
               m, a, rd, wr, ram_ce_n, ece);
    end
    checks++;
    if (ram_oe_n !== rd) begin
      errors++; $display("FAIL R1 oe addr=%h: got %b exp %b", a, ram_oe_n, rd);
    end
    checks++;
    if (ram_we_n !== ewe) begin
      errors++; $display("FAIL R2 we mode=%0d: got %b exp %b", m, ram_we_n, ewe);
    end
    if (m != 2'd1 || !ece) begin
      checks++;
      if (ram_addr !== exp_addr(m, a)) begin
        errors++;
        $display("FAIL %s addr mode=%0d bus=%h: got %h exp %h",
                 m == 1 ? "R6" : "R4/R8/R9", m, a, ram_addr, exp_addr(m, a));
      end
    end
    if (m == 2'd1 && !ram_ce_n && !rd && wr) begin
      checks++;
      if (occ[ram_addr]) begin
        errors++;
        $display("FAIL R7 alias bus=%h ram=%h: got occupied exp free", a, ram_addr);
      end
      occ[ram_addr] = 1'b1;
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [11:0] corners [0:10];
    corners = '{12'h000, 12'h1FF, 12'h200, 12'h7FF, 12'h800, 12'hAFF,
                12'hB00, 12'hBFF, 12'hC00, 12'hEFF, 12'hF00};
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 2048; i++) occ[i] = 1'b0;
    // reset state: no strobes, flat mode
    apply(2'd0, 12'h300, 1'b1, 1'b1);
    // directed page edges in every mode, both strobe polarities (R4 R5 R6 R8 R9)
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 11; c++) begin
        apply(2'(m), corners[c], 1'b0, 1'b1);
        apply(2'(m), corners[c], 1'b1, 1'b0);
        apply(2'(m), 12'hFFF, 1'b0, 1'b0);
      end
    // random vectors (occupancy only from the sweep below)
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] m; logic [11:0] a; logic rd, wr;
      m = 2'($urandom); a = 12'($urandom); rd = 1'($urandom); wr = 1'($urandom);
      if (m == 2'd1) begin rd = 1'b1; end
      apply(m, a, rd, wr);
    end
    for (int i = 0; i < 2048; i++) occ[i] = 1'b0;
    // exhaustive sweep; folded reads feed the R7 occupancy map
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 4096; a++)
          apply(2'(m), 12'(a), s[0], s[1]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule